// File: doc/BRIEF.md
# Indexed Address and Branch Sequencer

This block generates bus addresses, one cycle at a time, for the memory accesses that need address arithmetic inside an 8-bit CPU bus sequencer. It handles three operation kinds. An indexed read adds an unsigned 8-bit index to a 16-bit base address. This covers absolute,X and absolute,Y, and also (zero-page),Y once the caller has fetched the pointer and presents it as the base. An indexed store uses the same arithmetic. A taken relative branch adds a sign-extended 8-bit offset to the current program counter.

The low byte of the sum is formed first. While the high byte is not yet corrected, the block reads from a partially formed address: the old high byte with the new low byte. If the sum stays on the base's page, that read is already the real one, and a read operation finishes in one step. If a page is crossed, or the operation is a store, the first read is a discarded dummy and the correct address follows in the next step. A branch always starts with a dummy read at the old program counter. A branch that stays on its page ends there and raises a one-step interrupt-poll mask. A branch that crosses a page takes one more step.

The sequencer advances only on cycles where `step_en` is high, so the surrounding core can stretch bus cycles freely. Opcode decode, data capture and the ALU belong to the caller.

Top module: `idxbr_seq`

## Requirements
- R1: While reset is asserted and right after it, `bus_rd`, `exec_pulse`, `done` and `poll_mask` are all low.
- R2: Indexed read (mode 2'b00) whose sum `base+index` stays on the base's page (same upper 8 bits): in the first step after start, `bus_rd` is high at the sum, and `exec_pulse` and `done` are high in that same step.
- R3: Indexed read that crosses a page: the first step reads at {base[15:8], sum[7:0]} with `exec_pulse` and `done` low. The next step reads at the full sum with `exec_pulse` and `done` high.
- R4: Indexed store (mode 2'b01) always takes two steps, whether or not a page is crossed. The first is a dummy read at {base[15:8], sum[7:0]}. The second has `bus_rd` low, `exec_pulse` high and `done` high, with `bus_addr` at the sum.
- R5: Taken branch (mode 2'b10): the first step is a read at the old program counter (`base_addr`) with `exec_pulse` low. The target is base + sign-extended offset, and `calc_addr` shows it whenever `done` is high.
- R6: A branch whose target stays on the old page completes in its first step, with `done` and `poll_mask` both high for that one step only.
- R7: A branch whose target crosses a page adds a second step: a read at {old_pc[15:8], target[7:0]} with `done` high and `poll_mask` low.
- R8: On cycles with `step_en` low, no strobe is raised, the sequencer does not advance, and `bus_addr` holds its value.
- R9: A start request is ignored while an operation is in progress, and also ignored when the mode is the reserved code 2'b11. Start is accepted only while idle with `step_en` high.
- R10: All address arithmetic wraps modulo 2^16, and a wrap through the top of the address space counts as a page crossing.
- R11: `done` is a single-cycle pulse, raised exactly once per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | High on cycles where a bus step may occur |
| start | input | 1 | Request to begin an operation (taken while idle with step_en) |
| mode | input | 2 | 00 indexed read, 01 indexed store, 10 taken branch, 11 reserved |
| base_addr | input | 16 | Base address, fetched pointer, or old program counter |
| offset | input | 8 | Unsigned index, or signed branch displacement |
| bus_addr | output | 16 | Address of the current step |
| bus_rd | output | 1 | Read strobe for the current step |
| exec_pulse | output | 1 | Data at bus_addr is the operand (read) or the write slot (store) |
| done | output | 1 | Last step of the operation |
| poll_mask | output | 1 | Suppress interrupt polling for the next fetch |
| calc_addr | output | 16 | Final effective address or branch target |

## Verification
Indexed reads are run with sums that stay on the page, sums that land exactly one byte over a boundary, and a sum that wraps past 0xFFFF. This separates the one-step path from the dummy-read path and shows that the dummy read takes the old high byte. Stores are run both with and without a crossing, so that a design skipping the penalty step on same-page stores is exposed. Branches are run forward and backward, within the page and across it, and once wrapping below zero. These cases show sign extension, the poll mask that only a same-page branch raises, and the splice address of the extra step. Stalls with step_en low in the middle of an operation, extra start requests while busy, and the reserved mode check that nothing moves when it should not.

// File: rtl/idxbr_pkg.sv
package idxbr_pkg;

  parameter int unsigned AW = 16;
  parameter int unsigned OW = 8;
  localparam int unsigned HW = AW - OW;

  typedef enum logic [1:0] {
    MD_READ   = 2'b00,
    MD_STORE  = 2'b01,
    MD_BRANCH = 2'b10,
    MD_RSVD   = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SRC_BASE  = 2'd0,
    SRC_SPLIT = 2'd1,
    SRC_FINAL = 2'd2
  } addr_src_e;

  // widen an index (zero) or branch displacement (sign)
  function automatic logic [AW-1:0] f_extend(input logic [OW-1:0] v, input logic is_signed);
    if (is_signed) return {{HW{v[OW-1]}}, v};
    else           return {{HW{1'b0}}, v};
  endfunction

  function automatic logic [AW-1:0] f_add(input logic [AW-1:0] base,
                                          input logic [OW-1:0] v,
                                          input logic is_signed);
    return base + f_extend(v, is_signed);
  endfunction

  function automatic logic f_same_page(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:OW] == b[AW-1:OW];
  endfunction

  // high part from one address, low part from another
  function automatic logic [AW-1:0] f_splice(input logic [AW-1:0] hi_src,
                                             input logic [AW-1:0] lo_src);
    return {hi_src[AW-1:OW], lo_src[OW-1:0]};
  endfunction

endpackage

// File: rtl/idxbr_operands.sv
module idxbr_operands
  import idxbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  input  op_mode_e      mode_i,
  output logic [AW-1:0] base_q,
  output logic [OW-1:0] off_q,
  output op_mode_e      mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      mode_q <= MD_READ;
    end else if (load) begin
      base_q <= base_i;
      off_q  <= off_i;
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/idxbr_addr_calc.sv
module idxbr_addr_calc
  import idxbr_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] off,
  input  op_mode_e      mode,
  output logic [AW-1:0] final_addr,
  output logic [AW-1:0] split_addr,
  output logic          crosses
);

  logic is_branch;

  always_comb begin
    is_branch  = (mode == MD_BRANCH);
    final_addr = f_add(base, off, is_branch);
    split_addr = f_splice(base, final_addr);
    crosses    = !f_same_page(base, final_addr);
  end

endmodule

// File: rtl/idxbr_ctrl.sv
module idxbr_ctrl
  import idxbr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_en,
  input  logic      start,
  input  op_mode_e  mode_i,
  input  op_mode_e  mode_q,
  input  logic      crosses,
  output logic      load,
  output phase_e    phase,
  output addr_src_e addr_sel,
  output logic      rd,
  output logic      exec,
  output logic      done,
  output logic      poll_mask
);

  phase_e phase_nx;
  logic   need_second;

  assign need_second = (mode_q == MD_STORE) || crosses;
  assign load = (phase == PH_IDLE) && step_en && start && (mode_i != MD_RSVD);

  always_comb begin
    addr_sel  = SRC_BASE;
    rd        = 1'b0;
    exec      = 1'b0;
    done      = 1'b0;
    poll_mask = 1'b0;
    case (phase)
      PH_FIRST: begin
        rd = step_en;
        if (mode_q == MD_BRANCH) begin
          addr_sel  = SRC_BASE;
          done      = step_en && !crosses;
          poll_mask = step_en && !crosses;
        end else begin
          addr_sel = SRC_SPLIT;
          exec     = step_en && (mode_q == MD_READ) && !crosses;
          done     = step_en && (mode_q == MD_READ) && !crosses;
        end
      end
      PH_SECOND: begin
        addr_sel = (mode_q == MD_BRANCH) ? SRC_SPLIT : SRC_FINAL;
        rd       = step_en && (mode_q != MD_STORE);
        exec     = step_en && (mode_q != MD_BRANCH);
        done     = step_en;
      end
      default: addr_sel = SRC_BASE;
    endcase
  end

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:   if (load) phase_nx = PH_FIRST;
      PH_FIRST:  if (step_en) phase_nx = need_second ? PH_SECOND : PH_IDLE;
      PH_SECOND: if (step_en) phase_nx = PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R11: one-cycle done pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: the poll mask only accompanies the end of a branch
  p_mask_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_mask |-> (done && mode_q == MD_BRANCH));

  // R4: a store never finishes in its first step
  p_store_two_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && mode_q == MD_STORE) |-> (!exec && !done));

  // R9: no new operand capture while busy
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> !load);

  // R8: a stalled cycle leaves the phase where it was
  p_stall_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && phase != PH_IDLE) |=> $stable(phase));

endmodule

// File: rtl/idxbr_seq.sv
module idxbr_seq
  import idxbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base_addr,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          exec_pulse,
  output logic          done,
  output logic          poll_mask,
  output logic [AW-1:0] calc_addr
);

  op_mode_e      mode_in;
  op_mode_e      mode_q;
  logic [AW-1:0] base_q;
  logic [OW-1:0] off_q;
  logic [AW-1:0] final_addr;
  logic [AW-1:0] split_addr;
  logic          crosses;
  logic          load;
  phase_e        phase;
  addr_src_e     addr_sel;

  assign mode_in = op_mode_e'(mode);

  idxbr_operands u_ops (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .base_i (base_addr),
    .off_i  (offset),
    .mode_i (mode_in),
    .base_q (base_q),
    .off_q  (off_q),
    .mode_q (mode_q)
  );

  idxbr_addr_calc u_calc (
    .base       (base_q),
    .off        (off_q),
    .mode       (mode_q),
    .final_addr (final_addr),
    .split_addr (split_addr),
    .crosses    (crosses)
  );

  idxbr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .start     (start),
    .mode_i    (mode_in),
    .mode_q    (mode_q),
    .crosses   (crosses),
    .load      (load),
    .phase     (phase),
    .addr_sel  (addr_sel),
    .rd        (bus_rd),
    .exec      (exec_pulse),
    .done      (done),
    .poll_mask (poll_mask)
  );

  always_comb begin
    case (addr_sel)
      SRC_SPLIT: bus_addr = split_addr;
      SRC_FINAL: bus_addr = final_addr;
      default:   bus_addr = base_q;
    endcase
  end

  assign calc_addr = final_addr;

  // R3: the first access of an indexed operation stays on the base page
  p_first_on_base_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && phase == PH_FIRST && mode_q != MD_BRANCH)
      |-> (bus_addr[AW-1:OW] == base_q[AW-1:OW]));

  // R2: execute always happens at the fully formed address
  p_exec_at_final_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> (bus_addr == calc_addr));

  // R5: a branch begins with a read of the old program counter
  p_branch_old_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && mode_q == MD_BRANCH && bus_rd) |-> (bus_addr == base_q && !exec_pulse));

  // R8: the address holds across a stalled cycle
  p_stall_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && phase != PH_IDLE) |=> $stable(bus_addr));

  // R8: strobes only on enabled cycles
  p_no_strobe_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> !(bus_rd || exec_pulse || done || poll_mask));

endmodule

// File: tb/idxbr_seq_test.sv
module idxbr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] base_addr = '0;
  logic [7:0]  offset = '0;
  logic [15:0] bus_addr;
  logic        bus_rd, exec_pulse, done, poll_mask;
  logic [15:0] calc_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] addr;
    logic        rd, ex, dn, mk;
    logic [15:0] calc;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  idxbr_seq uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .start(start), .mode(mode),
    .base_addr(base_addr), .offset(offset), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .exec_pulse(exec_pulse), .done(done), .poll_mask(poll_mask), .calc_addr(calc_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  function automatic exp_t mk(input logic [15:0] a, input logic r, input logic e,
                              input logic d, input logic m, input logic [15:0] c,
                              input string req);
    exp_t t;
    t.addr = a; t.rd = r; t.ex = e; t.dn = d; t.mk = m; t.calc = c; t.req = req;
    return t;
  endfunction

  // expected step lists, worked out from the requirement text
  task automatic expect_op(input logic [1:0] md, input logic [15:0] b, input logic [7:0] o);
    logic [15:0] tgt, spl;
    bit same;
    if (md == 2'b10) tgt = b + {{8{o[7]}}, o};
    else             tgt = b + {8'h00, o};
    spl  = {b[15:8], tgt[7:0]};
    same = (b[15:8] == tgt[15:8]);
    case (md)
      2'b00: if (same) q.push_back(mk(tgt, 1, 1, 1, 0, tgt, "R2"));
             else begin
               q.push_back(mk(spl, 1, 0, 0, 0, tgt, "R3"));
               q.push_back(mk(tgt, 1, 1, 1, 0, tgt, "R3"));
             end
      2'b01: begin
               q.push_back(mk(spl, 1, 0, 0, 0, tgt, "R4"));
               q.push_back(mk(tgt, 0, 1, 1, 0, tgt, "R4"));
             end
      2'b10: if (same) q.push_back(mk(b, 1, 0, 1, 1, tgt, "R6"));
             else begin
               q.push_back(mk(b, 1, 0, 0, 0, tgt, "R5"));
               q.push_back(mk(spl, 1, 0, 1, 0, tgt, "R7"));
             end
      default: ;
    endcase
  endtask

  task automatic issue(input logic [1:0] md, input logic [15:0] b, input logic [7:0] o);
    @(posedge clk); #1;
    start = 1; mode = md; base_addr = b; offset = o;
    expect_op(md, b, o);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  // monitor: compare every strobed step against the queue
  always @(negedge clk) begin
    if (rst_n && (bus_rd || exec_pulse || done || poll_mask)) begin
      if (q.size() == 0) begin
        check(0, "R9", "unexpected strobe at addr", bus_addr, 16'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(bus_addr == e.addr, e.req, "bus_addr", bus_addr, e.addr);
        check({bus_rd, exec_pulse, done, poll_mask} == {e.rd, e.ex, e.dn, e.mk}, e.req,
              "rd/exec/done/mask", {bus_rd, exec_pulse, done, poll_mask}, {e.rd, e.ex, e.dn, e.mk});
        if (done) check(calc_addr == e.calc, (e.req == "R6" || e.req == "R7") ? "R5" : "R10",
                        "calc_addr", calc_addr, e.calc);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", "timeout", 0, 1);
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({bus_rd, exec_pulse, done, poll_mask} == 4'b0, "R1", "strobes in reset",
          {bus_rd, exec_pulse, done, poll_mask}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check({bus_rd, exec_pulse, done, poll_mask} == 4'b0, "R1", "strobes after reset",
          {bus_rd, exec_pulse, done, poll_mask}, 0);

    // R2 / R3 indexed reads
    issue(2'b00, 16'h1234, 8'h10); drain();
    issue(2'b00, 16'h20FE, 8'h01); drain();
    issue(2'b00, 16'h12F0, 8'h20); drain();
    issue(2'b00, 16'h12FF, 8'h01); drain();
    // R10 wrap through 0xFFFF
    issue(2'b00, 16'hFFF0, 8'h20); drain();
    // R4 stores, with and without a crossing
    issue(2'b01, 16'h3000, 8'h05); drain();
    issue(2'b01, 16'h30FE, 8'h03); drain();
    // R5/R6/R7 branches
    issue(2'b10, 16'h4010, 8'h05); drain();
    issue(2'b10, 16'h4010, 8'hF0); drain();
    issue(2'b10, 16'h40F0, 8'h20); drain();
    issue(2'b10, 16'h4005, 8'h80); drain();
    issue(2'b10, 16'h0002, 8'hF0); drain();

    // R8: stall between the two steps of a crossing read
    issue(2'b00, 16'h50F8, 8'h10);
    @(posedge clk); #1 step_en = 0;
    repeat (3) begin
      @(negedge clk);
      check(bus_addr == 16'h5108, "R8", "held address", bus_addr, 16'h5108);
      check({bus_rd, exec_pulse, done} == 3'b0, "R8", "strobes stalled",
            {bus_rd, exec_pulse, done}, 0);
    end
    @(posedge clk); #1 step_en = 1;
    drain();

    // R9: start held high while busy
    @(posedge clk); #1;
    start = 1; mode = 2'b00; base_addr = 16'h60F0; offset = 8'h20;
    expect_op(2'b00, 16'h60F0, 8'h20);
    @(posedge clk); #1 mode = 2'b01; base_addr = 16'h7777; offset = 8'h01;
    @(posedge clk); #1 start = 0;
    drain();
    repeat (3) @(posedge clk);
    check(q.size() == 0, "R9", "leftover expected steps", q.size(), 0);

    // R9: reserved mode does nothing
    @(posedge clk); #1 start = 1; mode = 2'b11; base_addr = 16'h1111; offset = 8'h11;
    @(posedge clk); #1 start = 0;
    repeat (4) begin
      @(negedge clk);
      check({bus_rd, exec_pulse, done} == 3'b0, "R9", "reserved mode strobes",
            {bus_rd, exec_pulse, done}, 0);
    end

    // R11: back-to-back operations, each done once
    issue(2'b00, 16'h0100, 8'h01);
    issue(2'b10, 16'h0200, 8'h02);
    drain();
    check(q.size() == 0, "R11", "queue drained", q.size(), 0);

    repeat (4) @(posedge clk);
    summary();
  end

endmodule